// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM's contents alive. Once reset is released it forbids every memory cycle for a fixed power-up pause. It then runs a set number of wake-up refresh cycles on its own, with no grant, and only after that raises `init_done`, which lets the host interface start issuing accesses. In normal operation an interval timer adds one owed refresh every period. For the default 1024 rows and 16 ms this period is about 15.6 µs. The sequencer requests the strobes from the access controller. When it is granted, it drives `ras_n` and `cas_n` itself to perform a CAS-before-RAS refresh. That cycle needs no address because the memory supplies the row from its own counter, and it moves no data.

All timings are parameters counted in clock cycles. A parameter picks one of two refresh policies. Distributed refresh requests each refresh as soon as it is owed. Burst refresh waits until a batch is owed and then drains the whole backlog. Owed refreshes are never lost. The request is marked urgent when the backlog reaches a limit. If the backlog ever exceeds the row count, the refresh deadline has been missed: the sequencer flags it, withdraws `init_done` and repeats the wake-up sequence.

The sequencer states are:
- PAUSE: counting the power-up pause.
- WAKE: issuing wake-up cycles.
- RUN: idle in operation.
- REQ: request raised.
- CYC: granted refresh in flight.

The transitions are:
- PAUSE→WAKE when the pause count ends.
- WAKE→RUN when the last wake-up cycle completes.
- RUN→REQ when a refresh is wanted.
- REQ→CYC on grant.
- CYC→RUN when the cycle completes.
- RUN/REQ→WAKE on a missed deadline.
- CYC→WAKE when the cycle completes with a missed deadline pending.

A separate engine walks the states IDLE, CAS_LEAD, RAS_LOW and PRECHG for each refresh cycle.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is held and right after reset, `ras_n` and `cas_n` are high, and `init_done`, `rfsh_req`, `rfsh_busy` and `deadline_miss` are low. Whenever the engine is idle, both strobes are high.
- R2: Neither strobe falls during the first PAUSE_CYC clock cycles after reset is released. The first `cas_n` fall comes in cycle PAUSE_CYC+1 or PAUSE_CYC+2.
- R3: After the pause, exactly WAKE_CYCLES refresh cycles run without any grant. `rfsh_req` stays low throughout. `init_done` then goes high.
- R4: Each refresh cycle has the following timing. `cas_n` is low for at least CSR_CYC cycles before `ras_n` falls. `cas_n` stays low for at least CHR_CYC cycles counted from the `ras_n` fall. `ras_n` stays low for at least RAS_CYC cycles. `ras_n` stays high for at least RP_CYC cycles before the next fall.
- R5: In operation, one refresh becomes owed every INTERVAL_CYC cycles, counted from the first cycle with `init_done` high. In distributed mode (BURST_MODE=0), `rfsh_req` is high whenever at least one refresh is owed. Each grant produces exactly one refresh cycle.
- R6: `rfsh_gnt` has no effect while `rfsh_req` is low. In operation, no strobe falls without a grant in the cycle before.
- R7: Refreshes owed while no grant is given are kept. Once grants resume, the number of refresh cycles equals the number of intervals elapsed.
- R8: `rfsh_urgent` is high exactly when a request is raised and the owed count is at least URGENT_LIMIT.
- R9: In burst mode (BURST_MODE=1), no request is raised until BURST_LEN refreshes are owed, unless the urgent limit is reached first. Once a refresh is granted, requests continue until nothing is owed. With grants always available, the refresh count is always a multiple of BURST_LEN.
- R10: When a refresh becomes owed with ROWS already owed, `deadline_miss` rises. `init_done` falls and WAKE_CYCLES wake-up cycles run again, after which `init_done` returns.
- R11: A raised `rfsh_req` stays high until it is granted, unless the deadline is missed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_gnt | input | 1 | Grant from the access controller; sampled only while a request is raised |
| rfsh_req | output | 1 | Refresh request toward the access controller |
| rfsh_urgent | output | 1 | Request is at top priority (owed count at or above the limit) |
| rfsh_busy | output | 1 | Refresh engine owns the strobes this cycle |
| ras_n | output | 1 | Row strobe, active low, driven during refresh cycles |
| cas_n | output | 1 | Column strobe, active low, driven during refresh cycles |
| init_done | output | 1 | Power-up and wake-up complete; host accesses allowed |
| deadline_miss | output | 1 | More refreshes owed than rows; wake-up will be re-run |

## Verification
Two configurations are exercised side by side: a distributed-policy instance with short intervals and a burst-policy instance with longer intervals.

The distributed instance first sees grants withheld for several intervals. This separates a design that keeps its backlog and escalates to urgent from one that drops requests. It then sees grants drawn at random each cycle, including while no request is raised. This separates grant-qualified refresh from refreshes started by stray grants, and shows that the refresh count tracks the elapsed intervals. Finally, grants are withheld until the deadline is missed, which exercises the re-run of the wake-up sequence.

The burst instance is always granted, so its refresh count tells a batching policy apart from a per-interval one. A timing monitor on both instances measures strobe ordering and pulse widths on every cycle.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    // Sequencer states (see brief for transitions)
    typedef enum logic [2:0] {
        SQ_PAUSE,
        SQ_WAKE,
        SQ_RUN,
        SQ_REQ,
        SQ_CYC
    } seq_state_e;

    // CAS-before-RAS engine states
    typedef enum logic [1:0] {
        EN_IDLE,
        EN_CAS_LEAD,
        EN_RAS_LOW,
        EN_PRECHG
    } eng_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
    parameter int INTERVAL_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_owed_ctr.sv
module rfsh_owed_ctr #(
    parameter int ROWS         = 1024,
    parameter int URGENT_LIMIT = 8,
    parameter int BURST_LEN    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic urgent,
    output logic burst_ready,
    output logic miss
);
    localparam int OW = $clog2(ROWS + 2);
    localparam logic [OW-1:0] CAP      = OW'(ROWS);
    localparam logic [OW-1:0] OVER     = OW'(ROWS + 1);
    localparam logic [OW-1:0] URG_LVL  = OW'(URGENT_LIMIT);
    localparam logic [OW-1:0] BURST_LVL = OW'(BURST_LEN);

    logic [OW-1:0] owed_q;
    logic          miss_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            owed_q <= '0;
            miss_q <= 1'b0;
        end else begin
            if (inc && !dec) begin
                if (owed_q != OVER) begin
                    owed_q <= owed_q + 1'b1;
                end
                if (owed_q == CAP) begin
                    miss_q <= 1'b1;
                end
            end else if (dec && !inc && owed_q != '0) begin
                owed_q <= owed_q - 1'b1;
            end
        end
    end

    assign nonzero     = (owed_q != '0);
    assign urgent      = (owed_q >= URG_LVL);
    assign burst_ready = (owed_q >= BURST_LVL);
    assign miss        = miss_q;
endmodule

// File: rtl/cbr_cycle_engine.sv
module cbr_cycle_engine
    import dram_rfsh_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 1,
    parameter int RAS_CYC = 7,
    parameter int RP_CYC  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int MAXC = max3(CSR_CYC, RAS_CYC, RP_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);
    localparam logic [CW-1:0] CHR_LEN  = CW'(CHR_CYC);

    eng_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          phase_end;

    always_comb begin
        unique case (st_q)
            EN_CAS_LEAD: phase_end = (cnt_q == CSR_LAST);
            EN_RAS_LOW:  phase_end = (cnt_q == RAS_LAST);
            EN_PRECHG:   phase_end = (cnt_q == RP_LAST);
            default:     phase_end = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_IDLE:     if (start)     st_d = EN_CAS_LEAD;
            EN_CAS_LEAD: if (phase_end) st_d = EN_RAS_LOW;
            EN_RAS_LOW:  if (phase_end) st_d = EN_PRECHG;
            EN_PRECHG:   if (phase_end) st_d = EN_IDLE;
            default:                    st_d = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= EN_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || st_q == EN_IDLE || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        idle  = (st_q == EN_IDLE);
        done  = (st_q == EN_PRECHG) && phase_end;
        ras_n = (st_q != EN_RAS_LOW);
        cas_n = !((st_q == EN_CAS_LEAD) ||
                  ((st_q == EN_RAS_LOW) && (cnt_q < CHR_LEN)));
    end
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int WAKE_CYCLES  = 8,
    parameter int ROWS         = 1024,
    parameter int INTERVAL_CYC = 1562,
    parameter int URGENT_LIMIT = 8,
    parameter int BURST_MODE   = 0,
    parameter int BURST_LEN    = 8,
    parameter int CSR_CYC      = 1,
    parameter int CHR_CYC      = 1,
    parameter int RAS_CYC      = 7,
    parameter int RP_CYC       = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_gnt,
    output logic rfsh_req,
    output logic rfsh_urgent,
    output logic rfsh_busy,
    output logic ras_n,
    output logic cas_n,
    output logic init_done,
    output logic deadline_miss
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int WW = $clog2(WAKE_CYCLES + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [WW-1:0] WAKE_LAST  = WW'(WAKE_CYCLES - 1);

    seq_state_e st_q, st_d;
    logic [PW-1:0] pause_q;
    logic [WW-1:0] wake_q;

    logic eng_start, eng_idle, eng_done;
    logic tick, owed_nz, owed_urg, owed_burst, owed_miss;
    logic in_oper, want_req;

    // ---------------- sub-blocks ----------------
    rfsh_tick_gen #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (in_oper),
        .tick (tick)
    );

    rfsh_owed_ctr #(
        .ROWS        (ROWS),
        .URGENT_LIMIT(URGENT_LIMIT),
        .BURST_LEN   (BURST_LEN)
    ) u_owed (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!in_oper),
        .inc        (tick),
        .dec        (eng_done && (st_q == SQ_CYC)),
        .nonzero    (owed_nz),
        .urgent     (owed_urg),
        .burst_ready(owed_burst),
        .miss       (owed_miss)
    );

    cbr_cycle_engine #(
        .CSR_CYC(CSR_CYC),
        .CHR_CYC(CHR_CYC),
        .RAS_CYC(RAS_CYC),
        .RP_CYC (RP_CYC)
    ) u_eng (
        .clk  (clk),
        .rst_n(rst_n),
        .start(eng_start),
        .idle (eng_idle),
        .done (eng_done),
        .ras_n(ras_n),
        .cas_n(cas_n)
    );

    // ---------------- refresh policy ----------------
    generate
        if (BURST_MODE != 0) begin : g_burst
            logic drain_q;
            always_ff @(posedge clk) begin
                if (!rst_n || !in_oper) begin
                    drain_q <= 1'b0;
                end else if (st_q == SQ_REQ && rfsh_gnt) begin
                    drain_q <= 1'b1;
                end else if (st_q == SQ_RUN && !owed_nz) begin
                    drain_q <= 1'b0;
                end
            end
            assign want_req = owed_burst || owed_urg || (drain_q && owed_nz);
        end else begin : g_dist
            assign want_req = owed_nz;
        end
    endgenerate

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SQ_PAUSE;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_PAUSE: if (pause_q == PAUSE_LAST) st_d = SQ_WAKE;
            SQ_WAKE:  if (eng_done && wake_q == WAKE_LAST) st_d = SQ_RUN;
            SQ_RUN: begin
                if (owed_miss)     st_d = SQ_WAKE;
                else if (want_req) st_d = SQ_REQ;
            end
            SQ_REQ: begin
                if (owed_miss)     st_d = SQ_WAKE;
                else if (rfsh_gnt) st_d = SQ_CYC;
            end
            SQ_CYC: if (eng_done) st_d = owed_miss ? SQ_WAKE : SQ_RUN;
            default: st_d = SQ_PAUSE;
        endcase
    end

    // ---------------- counters ----------------
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != SQ_PAUSE) begin
            pause_q <= '0;
        end else begin
            pause_q <= pause_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || st_q != SQ_WAKE) begin
            wake_q <= '0;
        end else if (eng_done) begin
            wake_q <= wake_q + 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_oper       = (st_q == SQ_RUN) || (st_q == SQ_REQ) || (st_q == SQ_CYC);
        init_done     = in_oper;
        rfsh_req      = (st_q == SQ_REQ);
        rfsh_urgent   = (st_q == SQ_REQ) && owed_urg;
        eng_start     = ((st_q == SQ_WAKE) && eng_idle) ||
                        ((st_q == SQ_REQ) && rfsh_gnt && !owed_miss);
        rfsh_busy     = !eng_idle;
        deadline_miss = owed_miss;
    end
endmodule

// File: rtl/dram_rfsh_seq_chk.sv
module dram_rfsh_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rfsh_gnt,
    input logic rfsh_req,
    input logic rfsh_busy,
    input logic ras_n,
    input logic cas_n,
    input logic init_done,
    input logic deadline_miss
);
    // R1: idle engine leaves both strobes inactive
    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_busy |-> (ras_n && cas_n));

    // R4: column strobe leads the row strobe
    p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R6: in operation a cycle only starts after a granted request
    p_grant_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && $past(init_done)) |-> $past(rfsh_req && rfsh_gnt));

    // R11: an ungranted request is held
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req && !rfsh_gnt && !deadline_miss) |=> rfsh_req);

    // R10: a missed deadline withdraws init_done once the strobes are free
    p_miss_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (deadline_miss && !rfsh_busy) |=> !init_done);
endmodule

bind dram_rfsh_seq dram_rfsh_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rfsh_gnt     (rfsh_gnt),
    .rfsh_req     (rfsh_req),
    .rfsh_busy    (rfsh_busy),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .init_done    (init_done),
    .deadline_miss(deadline_miss)
);

// File: tb/dram_rfsh_seq_tb_top.sv
module cbr_timing_mon #(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 1,
    parameter int RAS_CYC = 3,
    parameter int RP_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    output int   viol,
    output int   falls
);
    logic p_ras = 1'b1, p_cas = 1'b1;
    int ras_lo = 0, ras_hi = 1000, cas_lo = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            viol <= 0; falls <= 0; p_ras <= 1'b1; p_cas <= 1'b1;
            ras_lo <= 0; ras_hi <= 1000; cas_lo <= 0;
        end else begin
            if (p_ras && !ras_n) begin
                falls <= falls + 1;
                if (cas_n || cas_lo < CSR_CYC || ras_hi < RP_CYC) viol <= viol + 1;
            end
            if (!p_cas && cas_n && ras_lo < CHR_CYC) viol <= viol + 1;
            if (!p_ras && ras_n && ras_lo < RAS_CYC) viol <= viol + 1;
            ras_lo <= ras_n ? 0 : ras_lo + 1;
            ras_hi <= ras_n ? ras_hi + 1 : 0;
            cas_lo <= cas_n ? 0 : cas_lo + 1;
            p_ras  <= ras_n;
            p_cas  <= cas_n;
        end
    end
endmodule

module dram_rfsh_seq_tb_top;
    localparam int PAUSE = 50;
    localparam int WAKE  = 8;
    localparam int INT_D = 20;
    localparam int INT_B = 40;
    localparam int BLEN  = 4;
    localparam int URG_D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic gnt_d = 1'b0, gnt_b = 1'b0;
    logic req_d, urg_d, busy_d, ras_d, cas_d, init_d, miss_d;
    logic req_b, urg_b, busy_b, ras_b, cas_b, init_b, miss_b;

    dram_rfsh_seq #(
        .PAUSE_CYC(PAUSE), .WAKE_CYCLES(WAKE), .ROWS(16), .INTERVAL_CYC(INT_D),
        .URGENT_LIMIT(URG_D), .BURST_MODE(0), .BURST_LEN(BLEN),
        .CSR_CYC(1), .CHR_CYC(1), .RAS_CYC(3), .RP_CYC(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt_d), .rfsh_req(req_d),
        .rfsh_urgent(urg_d), .rfsh_busy(busy_d), .ras_n(ras_d), .cas_n(cas_d),
        .init_done(init_d), .deadline_miss(miss_d)
    );

    dram_rfsh_seq #(
        .PAUSE_CYC(PAUSE), .WAKE_CYCLES(WAKE), .ROWS(64), .INTERVAL_CYC(INT_B),
        .URGENT_LIMIT(6), .BURST_MODE(1), .BURST_LEN(BLEN),
        .CSR_CYC(1), .CHR_CYC(1), .RAS_CYC(3), .RP_CYC(2)
    ) dut_b_i (
        .clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt_b), .rfsh_req(req_b),
        .rfsh_urgent(urg_b), .rfsh_busy(busy_b), .ras_n(ras_b), .cas_n(cas_b),
        .init_done(init_b), .deadline_miss(miss_b)
    );

    int viol_d, viol_b, mfall_d, mfall_b;
    cbr_timing_mon #(.CSR_CYC(1), .CHR_CYC(1), .RAS_CYC(3), .RP_CYC(2)) mon_d (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_d), .cas_n(cas_d), .viol(viol_d), .falls(mfall_d));
    cbr_timing_mon #(.CSR_CYC(1), .CHR_CYC(1), .RAS_CYC(3), .RP_CYC(2)) mon_b (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_b), .cas_n(cas_b), .viol(viol_b), .falls(mfall_b));

    // ---------------- observation counters ----------------
    int rel_cyc = 0, first_cas_fall = 0;
    int run_cyc_d = 0, run_falls_d = 0, wake_falls_d = 0;
    int run_cyc_b = 0, run_falls_b = 0, wake_falls_b = 0;
    logic pr_d = 1'b1, pr_b = 1'b1, pc_d = 1'b1;
    logic seen_init_d = 1'b0, req_early_d = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            rel_cyc   <= rel_cyc + 1;
            run_cyc_d <= init_d ? run_cyc_d + 1 : 0;
            run_cyc_b <= init_b ? run_cyc_b + 1 : 0;
            if (pc_d && !cas_d && first_cas_fall == 0) first_cas_fall <= rel_cyc + 1;
            if (pr_d && !ras_d) begin
                if (init_d) run_falls_d <= run_falls_d + 1;
                else        wake_falls_d <= wake_falls_d + 1;
            end
            if (pr_b && !ras_b) begin
                if (init_b) run_falls_b <= run_falls_b + 1;
                else        wake_falls_b <= wake_falls_b + 1;
            end
            if (init_d) seen_init_d <= 1'b1;
            if (req_d && !seen_init_d) req_early_d <= 1'b1;
            pr_d <= ras_d; pr_b <= ras_b; pc_d <= cas_d;
        end
    end

    // grant drivers: 0 = withheld, 1 = random, 2 = always
    int gmode = 0;
    always @(negedge clk) begin
        case (gmode)
            1:       gnt_d <= (($urandom % 4) != 0);
            2:       gnt_d <= 1'b1;
            default: gnt_d <= 1'b0;
        endcase
        gnt_b <= rst_n;
    end

    // ---------------- checking helpers ----------------
    int n_chk = 0, n_fail = 0;
    bit burst_fin = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int run_point(input int ticks, input int interval, input int phase);
        return ticks * interval + phase + 1;
    endfunction

    function automatic int burst_expect(input int ticks);
        return (ticks / BLEN) * BLEN;
    endfunction

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic wait_run_d(input int target);
        int lim = 0;
        while (run_cyc_d != target && lim < 5000) begin settle(); lim++; end
    endtask

    task automatic wait_run_b(input int target);
        int lim = 0;
        while (run_cyc_b != target && lim < 5000) begin settle(); lim++; end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- distributed instance ----------------
    initial begin
        int base, lim;
        void'($urandom(32'd2024));
        repeat (3) settle();
        // R1: values under reset
        check(ras_d && cas_d && !init_d && !req_d && !busy_d && !miss_d,
              "R1 reset outputs", {ras_d, cas_d, init_d, req_d}, 4'b1100);
        rst_n = 1'b1;
        settle();
        check(ras_d && cas_d && !init_d && !req_d, "R1 after release",
              {ras_d, cas_d, init_d, req_d}, 4'b1100);

        lim = 0;
        while (!init_d && lim < 2000) begin settle(); lim++; end
        // R2: pause honoured
        check(first_cas_fall > PAUSE && first_cas_fall <= PAUSE + 2,
              "R2 first strobe cycle", first_cas_fall, PAUSE + 1);
        // R3: wake-up count and no request during it
        check(wake_falls_d == WAKE, "R3 wake cycles", wake_falls_d, WAKE);
        check(!req_early_d, "R3 request before init", req_early_d, 0);

        // Phase A: grants withheld
        gmode = 0;
        wait_run_d(run_point(1, INT_D, 15));
        check(req_d == 1'b1, "R5 request after one interval", req_d, 1);
        check(urg_d == 1'b0, "R8 not urgent with one owed", urg_d, 0);
        wait_run_d(run_point(URG_D + 1, INT_D, 15));
        check(urg_d == 1'b1, "R8 urgent at limit", urg_d, 1);
        check(req_d == 1'b1, "R11 request held without grant", req_d, 1);
        check(run_falls_d == 0, "R6 no cycle without grant", run_falls_d, 0);

        // Phase B: random grants, also while no request is raised
        gmode = 1;
        for (int t = 15; t < 21; t++) begin
            wait_run_d(run_point(t, INT_D, 15));
            check(run_falls_d == t, "R7 refreshes equal intervals", run_falls_d, t);
        end
        check(!req_d, "R5 request clears when nothing owed", req_d, 0);
        check(viol_d == 0 && mfall_d > WAKE, "R4 strobe timing distributed", viol_d, 0);

        // Phase C: withhold grants until the deadline is missed
        gmode = 0;
        lim = 0;
        while (!miss_d && lim < 2000) begin settle(); lim++; end
        check(miss_d == 1'b1, "R10 deadline flagged", miss_d, 1);
        base = wake_falls_d;
        settle(); settle();
        check(init_d == 1'b0, "R10 init withdrawn", init_d, 0);
        lim = 0;
        while (!init_d && lim < 2000) begin settle(); lim++; end
        check(init_d && (wake_falls_d - base) == WAKE, "R10 wake-up rerun",
              wake_falls_d - base, WAKE);
        check(!miss_d, "R10 flag cleared after wake-up", miss_d, 0);

        lim = 0;
        while (!burst_fin && lim < 5000) begin settle(); lim++; end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- burst instance ----------------
    initial begin
        int lim = 0;
        while (!init_b && lim < 3000) begin settle(); lim++; end
        check(wake_falls_b == WAKE, "R3 wake cycles burst", wake_falls_b, WAKE);
        wait_run_b(run_point(BLEN - 1, INT_B, 38));
        check(run_falls_b == 0, "R9 no request below batch", run_falls_b, 0);
        for (int t = BLEN; t < 3 * BLEN + 2; t++) begin
            wait_run_b(run_point(t, INT_B, 38));
            check(run_falls_b == burst_expect(t), "R9 batch drained",
                  run_falls_b, burst_expect(t));
        end
        check(viol_b == 0 && mfall_b > WAKE, "R4 strobe timing burst", viol_b, 0);
        burst_fin = 1'b1;
    end
endmodule